// File: doc/BRIEF.md
# Clocked Inertial Pulse-Rejection Delay

This block delays a single-bit signal by a fixed number of clock cycles and, in its default mode, behaves like a gate with inertial delay: a level on the input that holds for fewer cycles than a reject limit never reaches the output. A level that holds for at least the reject limit is copied to the output unchanged in width, shifted by the fixed delay. The delay and the reject limit are separate static parameters, with the reject limit no larger than the delay and equal to it unless set otherwise.

A mode input switches the block to transport behaviour, in which nothing is filtered and every input level, however brief, appears on the output after the same delay. The block keeps a history of the last DLY input samples. The oldest sample is the candidate output value, and the newest samples show whether that candidate level lasted long enough to be committed.

Top module: `pulse_reject_delay`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout` takes the idle level `IDLE_LVL` (default 0) and the history fills with that level, so `dout` also shows `IDLE_LVL` for the first DLY clock edges after reset is released.
- R2: A `din` level that is not filtered, sampled at clock edge k, appears on `dout` after clock edge k+DLY.
- R3: With `mode_transport` = 0 (inertial), a `din` level that lasts fewer than REJ consecutive samples never appears on `dout`. For example, with DLY = REJ = 2, a 1-cycle pulse leaves `dout` unchanged.
- R4: A level that lasts exactly REJ samples passes and appears on `dout` with the same width, delayed by DLY.
- R5: A level that lasts longer than REJ samples passes intact, delayed by DLY.
- R6: REJ defaults to DLY and may be set lower, for example REJ = 3 with DLY = 5. The lower limit then passes a 3-cycle pulse that the default limit rejects.
- R7: A parameter set with REJ greater than DLY, or REJ below 1, is flagged when the design is elaborated.
- R8: With `mode_transport` = 1, every `din` level, including a 1-cycle pulse, is copied to `dout` after DLY edges.
- R9: With DLY = REJ = 5, an input edge at cycle 10 followed by the opposite edge at cycle 13 cancels the output change due at cycle 15, and `dout` keeps its previous level throughout.
- R10: In inertial mode, a dip shorter than REJ inside a long level is removed, and `dout` holds that level without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_transport | input | 1 | 0 = inertial (filtering), 1 = transport (no filtering) |
| din | input | 1 | Data input |
| dout | output | 1 | Delayed, optionally filtered data output |

## Verification
An input sampled at edge k can only affect `dout` at edge k+DLY. The scoreboard therefore stamps every expected item with the cycle counter value at the driving falling edge plus DLY+1, and the monitor compares `dout` only at the falling edge whose counter matches that stamp. The expected level comes from a run-length model of the stimulus, which looks ahead REJ samples. Right after each reset release, DLY items at the idle level are queued so that the first outputs are checked too. The bench waits until every queue has drained before it asserts reset again or changes the mode, so no expected value is left in flight across a reset.

// File: rtl/prd_pkg.sv
// Package for the pulse-reject delay line.
// Holds the mode encoding that the top level and the commit stage share.
package prd_pkg;
    typedef enum logic {
        MODE_INERTIAL  = 1'b0,
        MODE_TRANSPORT = 1'b1
    } prd_mode_e;
endpackage

// File: rtl/prd_history.sv
// prd_history: a shift register of DEPTH input samples.
// Bit 0 holds the newest sample and bit DEPTH-1 the oldest.
// Assumes a synchronous active-low reset, which loads IDLE_LVL into every stage.
module prd_history #(
    parameter int unsigned DEPTH    = 5,
    parameter logic        IDLE_LVL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] hist
);
    // Shift a new sample in each cycle; reset fills the history with the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= {DEPTH{IDLE_LVL}};
        else if (DEPTH == 1) hist <= din;
        else hist <= {hist[DEPTH-2:0], din};
    end

    // The newest stage always holds the sample taken at the previous edge.
    assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hist[0] == $past(din));
endmodule

// File: rtl/prd_run_check.sv
// prd_run_check: combinational run-length test on the history.
// It exposes the oldest sample as the tap.
// settled is high when the REJ oldest samples (the tap and the REJ-1 samples after it) all agree.
// Assumes 1 <= REJ <= DEPTH.
module prd_run_check #(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned REJ   = 5
) (
    input  logic [DEPTH-1:0] hist,
    output logic             tap,
    output logic             settled
);
    localparam int unsigned LO = DEPTH - REJ;

    logic [REJ-1:0] window;

    // Select the oldest REJ samples and test them for a single common level.
    always_comb begin
        window  = hist[DEPTH-1:LO];
        tap     = hist[DEPTH-1];
        settled = (&window) | ~(|window);
    end
endmodule

// File: rtl/prd_commit.sv
// prd_commit: the output register.
// In transport mode it copies the tap every cycle.
// In inertial mode it takes the tap only when the run-length test reports a settled level.
// Assumes a synchronous active-low reset to IDLE_LVL.
module prd_commit #(
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  prd_pkg::prd_mode_e mode,
    input  logic            tap,
    input  logic            settled,
    output logic            dout
);
    import prd_pkg::*;

    // Commit the tap when transport is selected or the candidate level lasted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= IDLE_LVL;
        else if (mode == MODE_TRANSPORT || settled) dout <= tap;
    end

    // Any output change must land on the tap level seen one cycle earlier.
    assert_change_is_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> dout == $past(tap));

    // When the tap already equals the output, the output holds on the next edge.
    assert_hold_when_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tap == dout) |=> $stable(dout));
endmodule

// File: rtl/pulse_reject_delay.sv
// pulse_reject_delay: a single-bit delay line of DLY cycles with inertial pulse rejection.
// In inertial mode, a level lasting fewer than REJ samples is dropped.
// In transport mode, every level passes.
// Assumes 1 <= REJ <= DLY, which is checked when the design is elaborated.
module pulse_reject_delay #(
    parameter int unsigned DLY      = 5,
    parameter int unsigned REJ      = DLY,
    parameter logic        IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_transport,
    input  logic din,
    output logic dout
);
    import prd_pkg::*;

    logic [DLY-1:0] hist;
    logic           tap;
    logic           settled;
    prd_mode_e      mode;

    // Map the raw mode pin onto the shared mode type.
    always_comb mode = mode_transport ? MODE_TRANSPORT : MODE_INERTIAL;

    prd_history #(.DEPTH(DLY), .IDLE_LVL(IDLE_LVL)) u_hist (
        .clk(clk), .rst_n(rst_n), .din(din), .hist(hist)
    );

    prd_run_check #(.DEPTH(DLY), .REJ(REJ)) u_run (
        .hist(hist), .tap(tap), .settled(settled)
    );

    prd_commit #(.IDLE_LVL(IDLE_LVL)) u_commit (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tap(tap), .settled(settled), .dout(dout)
    );

    // Flag an illegal reject limit when the design is elaborated.
    initial begin
        assert_rej_legal_R7: assert (REJ >= 1 && REJ <= DLY)
            else $error("reject limit %0d outside 1..%0d", REJ, DLY);
    end

    // In inertial mode, an output change needs agreement across the whole window one cycle earlier.
    assert_inertial_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dout) && !$past(mode_transport)) |-> $past(hist[DLY-1]) == $past(hist[DLY-REJ]));
endmodule

// File: tb/pulse_reject_delay_bench.sv
`timescale 1ns/1ps
// Scoreboard bench.
// Three instances: the default DLY=REJ=5, a variant with REJ=3 (R6), and DLY=REJ=2.
// R7 (an illegal REJ) is an elaboration-time check, so this bench uses only legal sets.
module pulse_reject_delay_bench;
    typedef struct {
        int    due;
        logic  val;
        string tag;
    } item_t;

    localparam int NI = 3;
    localparam int DL [NI] = '{5, 5, 2};
    localparam int RJ [NI] = '{5, 3, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_transport = 1'b0;
    logic din = 1'b0;
    logic [NI-1:0] dout;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    item_t q0[$];
    item_t q1[$];
    item_t q2[$];

    logic seg [0:127];
    int seg_len;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_reject_delay u_pulse_reject_delay (.clk(clk), .rst_n(rst_n), .mode_transport(mode_transport), .din(din), .dout(dout[0]));
    // R6: a reject limit below the delay
    pulse_reject_delay #(.DLY(5), .REJ(3)) u_pulse_reject_delay_r3 (.clk(clk), .rst_n(rst_n), .mode_transport(mode_transport), .din(din), .dout(dout[1]));
    pulse_reject_delay #(.DLY(2), .REJ(2)) u_pulse_reject_delay_d2 (.clk(clk), .rst_n(rst_n), .mode_transport(mode_transport), .din(din), .dout(dout[2]));

    task automatic push(input int k, input item_t it);
        case (k)
            0: q0.push_back(it);
            1: q1.push_back(it);
            default: q2.push_back(it);
        endcase
    endtask

    task automatic check(input int k, input logic act, input item_t it);
        n_chk++;
        if (act !== it.val) begin
            n_fail++;
            $display("FAIL %s inst%0d cycle %0d: dout=%b expected %b", it.tag, k, cyc, act, it.val);
        end
    endtask

    // Monitor: at each falling edge, pop the items that fall due now and compare them.
    always @(negedge clk) begin
        while (q0.size() > 0 && q0[0].due == cyc) check(0, dout[0], q0.pop_front());
        while (q1.size() > 0 && q1[0].due == cyc) check(1, dout[1], q1.pop_front());
        while (q2.size() > 0 && q2[0].due == cyc) check(2, dout[2], q2.pop_front());
    end

    task automatic put(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            seg[seg_len] = lvl;
            seg_len++;
        end
    endtask

    // Reset for three cycles and check that the outputs hold the idle level (R1).
    task automatic do_reset(input logic tmode);
        @(negedge clk);
        rst_n = 1'b0;
        din = 1'b0;
        mode_transport = tmode;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            for (int k = 0; k < NI; k++) begin
                n_chk++;
                if (dout[k] !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R1 reset inst%0d: dout=%b expected 0", k, dout[k]);
                end
            end
        end
    endtask

    // Driver: release reset, drive the segment and queue the expected outputs from a run-length model.
    task automatic run_seg(input logic tmode);
        logic  mo [NI];
        item_t it;
        bit    ok;
        int    c0;
        do_reset(tmode);
        c0 = cyc;
        for (int k = 0; k < NI; k++) begin
            mo[k] = 1'b0;
            for (int d = 1; d <= DL[k]; d++) begin
                it.due = c0 + d;
                it.val = 1'b0;
                it.tag = "R1 idle after reset";
                push(k, it);
            end
        end
        for (int i = 0; i < seg_len; i++) begin
            if (i == 0) rst_n = 1'b1;
            din = seg[i];
            for (int k = 0; k < NI; k++) begin
                if (tmode) begin
                    mo[k] = seg[i];
                end else begin
                    ok = 1;
                    for (int j = 0; j < RJ[k]; j++)
                        if (i + j < seg_len && seg[i + j] != seg[i]) ok = 0;
                    if (ok) mo[k] = seg[i];
                end
                it.due = cyc + DL[k] + 1;
                it.val = mo[k];
                if (tmode) it.tag = "R8 transport copy";
                else if (mo[k] != seg[i]) it.tag = (k == 1) ? "R6 R3 rejected" : "R3 R9 R10 rejected";
                else it.tag = (k == 1) ? "R6 R4 R5 delayed" : "R2 R4 R5 delayed";
                push(k, it);
            end
            @(negedge clk);
        end
        // Wait until every queue has drained.
        for (int i = 0; i < 8; i++) @(negedge clk);
    endtask

    initial begin
        // Inertial segment.
        seg_len = 0;
        put(0, 4);
        put(1, 1);   // R3: 1-cycle pulse dropped everywhere, including DLY=REJ=2
        put(0, 8);
        put(1, 2);   // R4: exactly REJ for the DLY=2 instance
        put(0, 8);
        put(1, 3);   // R9: edge then opposite edge 3 cycles later cancels for REJ=5; R6/R4 passes for REJ=3
        put(0, 8);
        put(1, 5);   // R4: exactly REJ for the default instance
        put(0, 8);
        put(1, 9);   // R5: longer than REJ
        put(0, 2);   // R10: short dip inside a long high level
        put(1, 7);
        put(0, 10);
        run_seg(1'b0);
        // Transport segment.
        seg_len = 0;
        put(0, 3);
        put(1, 1);   // R8: 1-cycle glitch must pass
        put(0, 3);
        put(1, 2);
        put(0, 1);
        put(1, 1);
        put(0, 10);
        run_seg(1'b1);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule